// File: doc/BRIEF.md
# Boundary-test access port with identification and debug chains

This block is the serial test port of a chip: a four-wire scan interface (test clock, mode select, data in, data out with its output enable) plus a power-on reset. A sixteen-state controller, advanced on each rising test-clock edge by the sampled mode-select bit, steps the port through its capture, shift, pause and update phases. An instruction chain with a parallel stage picks which data chain sits between data-in and data-out. The data chains are a one-bit pass-through chain, a 32-bit identification chain, and a debug-access chain.

The debug-access chain captures the result of the previous transaction, together with a 3-bit acknowledge code, from the system side. On its update phase it hands the shifted-in word to the system side with a one-period strobe. Instruction codes the block does not implement fall back to the pass-through chain, so a serial path always exists. The test logic answers only to the power-on reset and to the five-ones mode-select sequence. Data-out changes on the falling test-clock edge and is enabled only while a chain is shifting.

Top module: `tap_port`

## Requirements
- R1: `tms` and `tdi` are sampled on the rising edge of `tck`. The controller follows the standard sixteen-state scan graph, with the next state set by the current state and the sampled `tms`.
- R2: Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. In that state `cur_instr` reads the identification code 4'h2 at once, and the debug update register clears.
- R3: `por_n` is a synchronous active-low reset and the only reset of the test logic. It puts the controller in Test-Logic-Reset, `cur_instr` to 4'h2, and `tdo_oe` low.
- R4: The instruction chain is 4 bits wide and shifts least significant bit first. Capture-IR loads 4'b0001, and Update-IR copies the shifted value to `cur_instr`.
- R5: Code 4'h2 selects the identification chain, 4'h8 selects the debug chain, and 4'hF selects the pass-through chain. Every other code selects the pass-through chain.
- R6: The pass-through chain is one bit wide and captures 0, so a bit on `tdi` appears on `tdo` one shift later.
- R7: The identification chain is 32 bits wide and captures `ID_VALUE` with bit 0 forced to 1.
- R8: The debug chain is DATA_W+ACK_W bits wide. Capture-DR loads `{dbg_result, dbg_ack}`, which puts the acknowledge in bits [2:0] so that it shifts out first.
- R9: Update-DR with code 4'h8 copies the debug chain to `dbg_req_data`, and `dbg_req_valid` is high for exactly one `tck` period after that edge. An Update-DR with any other instruction leaves both unchanged.
- R10: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data into the selected chain |
| dbg_result | input | DATA_W | Result of the previous debug transaction |
| dbg_ack | input | ACK_W | Acknowledge code of the previous transaction |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | High while data-out is actively driven |
| cur_instr | output | 4 | Instruction now in force |
| dbg_req_data | output | DATA_W+ACK_W | Word handed to the system side on debug update |
| dbg_req_valid | output | 1 | One-period strobe for `dbg_req_data` |

## Verification
Each shift bit appears on `tdo` at the falling edge that follows the rising edge entering or advancing Shift. The bench therefore reads `tdo` and `tdo_oe` 1 ns after each falling edge, before it drives the next `tms`/`tdi` pair for the coming rising edge. `cur_instr` is due right after the rising edge leaving Update-IR, or right after the edge that enters Test-Logic-Reset. `dbg_req_valid` and `dbg_req_data` are due after the rising edge leaving Update-DR, and the strobe is checked low again one period later. A probe 1 ns after the rising edge into Shift-DR confirms that `tdo_oe` has not yet moved.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
// tap_pkg: controller state encoding, instruction codes, chain select
// indices and the next-state function shared by the scan port modules.
package tap_pkg;

    localparam int IR_W = 4;
    localparam int NSEL = 3;
    localparam int SEL_BYP = 0;
    localparam int SEL_ID  = 1;
    localparam int SEL_DBG = 2;

    localparam logic [IR_W-1:0] INS_IDCODE  = 4'h2;
    localparam logic [IR_W-1:0] INS_DEBUG   = 4'h8;
    localparam logic [IR_W-1:0] INS_BYPASS  = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    // Next controller state for the current state and sampled mode bit.
    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            ST_RESET:  return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            default:   return m ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
// tap_fsm: sixteen-state scan controller.
// Assumes tms is stable around the rising edge of tck; por_n is synchronous.
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);

    // Advance the controller on each rising test-clock edge.
    always_ff @(posedge tck) begin
        if (!por_n) state <= ST_RESET;
        else        state <= tap_next(state, tms);
    end

    // Checker: count consecutive high mode bits, saturating at five.
    logic [2:0] hi_run;
    always_ff @(posedge tck) begin
        if (!por_n)      hi_run <= 3'd0;
        else if (!tms)   hi_run <= 3'd0;
        else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
    end

    // R2
    five_ones_reset_chk: assert property (@(posedge tck) disable iff (!por_n)
        (hi_run == 3'd5) |-> (state == ST_RESET));

    // R1
    select_ir_exit_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_SEL_IR && !tms) |=> (state == ST_CAP_IR));

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
// tap_ir: instruction shift chain and its parallel stage.
// Assumes the controller state from tap_fsm; the instruction reads the
// identification code at once while the controller sits in reset.
module tap_ir
    import tap_pkg::*;
(
    input  logic             tck,
    input  logic             por_n,
    input  tap_state_e       state,
    input  logic             tdi,
    output logic             ir_lsb,
    output logic [IR_W-1:0]  instr
);

    logic [IR_W-1:0] sr_q;
    logic [IR_W-1:0] instr_q;

    // Capture, shift and update the instruction chain.
    always_ff @(posedge tck) begin
        if (!por_n || state == ST_RESET) begin
            sr_q    <= '0;
            instr_q <= INS_IDCODE;
        end else begin
            case (state)
                ST_CAP_IR: sr_q    <= IR_CAPTURE;
                ST_SH_IR:  sr_q    <= {tdi, sr_q[IR_W-1:1]};
                ST_UPD_IR: instr_q <= sr_q;
                default:   ;
            endcase
        end
    end

    // Present the identification code as soon as reset state is entered.
    always_comb instr = (state == ST_RESET) ? INS_IDCODE : instr_q;
    assign ir_lsb = sr_q[0];

    // R4
    ir_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_IR) |=> (ir_lsb == 1'b1));

    // R2
    reset_instr_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_RESET) |=> (instr_q == INS_IDCODE));

endmodule

// File: rtl/tap_decode.sv
`timescale 1ns/1ps
// tap_decode: maps the instruction in force to a one-hot chain select.
// Any code without its own chain selects the pass-through chain.
module tap_decode
    import tap_pkg::*;
(
    input  logic [IR_W-1:0] instr,
    output logic [NSEL-1:0] sel
);

    // One-hot select; unknown codes fall back to pass-through.
    always_comb begin
        sel = '0;
        case (instr)
            INS_IDCODE: sel[SEL_ID]  = 1'b1;
            INS_DEBUG:  sel[SEL_DBG] = 1'b1;
            default:    sel[SEL_BYP] = 1'b1;
        endcase
    end

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
// tap_dr: pass-through, identification and debug-access data chains.
// Assumes a one-hot select from tap_decode; only the selected chain
// captures, shifts or updates. Reset state clears every chain.
module tap_dr
    import tap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h4BA0_1C34,
    parameter int DATA_W = 32,
    parameter int ACK_W  = 3,
    localparam int DBG_W = DATA_W + ACK_W
) (
    input  logic              tck,
    input  logic              por_n,
    input  tap_state_e        state,
    input  logic [NSEL-1:0]   sel,
    input  logic              tdi,
    input  logic [DATA_W-1:0] dbg_result,
    input  logic [ACK_W-1:0]  dbg_ack,
    output logic              dr_lsb,
    output logic [DBG_W-1:0]  dbg_req_data,
    output logic              dbg_req_valid
);

    localparam logic [31:0] ID_CAP = ID_VALUE | 32'h1;

    logic             byp_q;
    logic [31:0]      id_q;
    logic [DBG_W-1:0] dbg_q;

    // Capture and shift the selected chain.
    always_ff @(posedge tck) begin
        if (!por_n || state == ST_RESET) begin
            byp_q <= 1'b0;
            id_q  <= '0;
            dbg_q <= '0;
        end else if (state == ST_CAP_DR) begin
            if (sel[SEL_BYP]) byp_q <= 1'b0;
            if (sel[SEL_ID])  id_q  <= ID_CAP;
            if (sel[SEL_DBG]) dbg_q <= {dbg_result, dbg_ack};
        end else if (state == ST_SH_DR) begin
            if (sel[SEL_BYP]) byp_q <= tdi;
            if (sel[SEL_ID])  id_q  <= {tdi, id_q[31:1]};
            if (sel[SEL_DBG]) dbg_q <= {tdi, dbg_q[DBG_W-1:1]};
        end
    end

    // Hand the debug word to the system side on its update phase.
    always_ff @(posedge tck) begin
        if (!por_n || state == ST_RESET) begin
            dbg_req_data  <= '0;
            dbg_req_valid <= 1'b0;
        end else begin
            dbg_req_valid <= (state == ST_UPD_DR) && sel[SEL_DBG];
            if (state == ST_UPD_DR && sel[SEL_DBG]) dbg_req_data <= dbg_q;
        end
    end

    // Serial output of the selected chain.
    always_comb begin
        if (sel[SEL_ID])       dr_lsb = id_q[0];
        else if (sel[SEL_DBG]) dr_lsb = dbg_q[0];
        else                   dr_lsb = byp_q;
    end

    // R5
    sel_onehot_chk: assert property (@(posedge tck) disable iff (!por_n)
        $onehot(sel));

    // R6
    byp_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_DR && sel[SEL_BYP]) |=> (dr_lsb == 1'b0));

    // R7
    id_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_DR && sel[SEL_ID]) |=> (dr_lsb == 1'b1));

    // R9
    upd_strobe_src_chk: assert property (@(posedge tck) disable iff (!por_n)
        dbg_req_valid |-> $past(state == ST_UPD_DR));

    // R9
    upd_strobe_width_chk: assert property (@(posedge tck) disable iff (!por_n)
        dbg_req_valid |=> !dbg_req_valid);

    // R9
    upd_data_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
        (!dbg_req_valid && state != ST_RESET) |=> $stable(dbg_req_data) || dbg_req_valid);

endmodule

// File: rtl/tap_port.sv
`timescale 1ns/1ps
// tap_port: top of the serial test port. Ties controller, instruction
// chain, decoder and data chains together and times data-out on the
// falling test-clock edge. Assumes por_n is held low across at least one
// full tck period so both clock edges see it.
module tap_port
    import tap_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h4BA0_1C34,
    parameter int DATA_W = 32,
    parameter int ACK_W  = 3,
    localparam int DBG_W = DATA_W + ACK_W
) (
    input  logic              tck,
    input  logic              por_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [DATA_W-1:0] dbg_result,
    input  logic [ACK_W-1:0]  dbg_ack,
    output logic              tdo,
    output logic              tdo_oe,
    output logic [IR_W-1:0]   cur_instr,
    output logic [DBG_W-1:0]  dbg_req_data,
    output logic              dbg_req_valid
);

    tap_state_e      state;
    logic            ir_lsb;
    logic            dr_lsb;
    logic [NSEL-1:0] sel;

    tap_fsm u_fsm (.tck(tck), .por_n(por_n), .tms(tms), .state(state));

    tap_ir u_ir (.tck(tck), .por_n(por_n), .state(state), .tdi(tdi),
                 .ir_lsb(ir_lsb), .instr(cur_instr));

    tap_decode u_dec (.instr(cur_instr), .sel(sel));

    tap_dr #(.ID_VALUE(ID_VALUE), .DATA_W(DATA_W), .ACK_W(ACK_W)) u_dr (
        .tck(tck), .por_n(por_n), .state(state), .sel(sel), .tdi(tdi),
        .dbg_result(dbg_result), .dbg_ack(dbg_ack), .dr_lsb(dr_lsb),
        .dbg_req_data(dbg_req_data), .dbg_req_valid(dbg_req_valid));

    // Retime serial output and its enable onto the falling edge.
    always_ff @(negedge tck) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
            tdo    <= (state == ST_SH_IR) ? ir_lsb :
                      (state == ST_SH_DR) ? dr_lsb : 1'b0;
        end
    end

    // R10
    oe_only_shift_chk: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R10
    oe_follows_shift_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_SH_DR && $past(state == ST_SH_DR)) |-> tdo_oe);

endmodule

// File: tb/tap_port_test.sv
`timescale 1ns/1ps
// tap_port_test: vector table over instruction codes, then directed tests.
module tap_port_test;

    localparam logic [31:0] IDV  = 32'h4BA0_1C34;
    localparam logic [31:0] IDX  = 32'h4BA0_1C35;
    localparam logic [31:0] RES  = 32'hC0DE_5A17;
    localparam logic [2:0]  ACK  = 3'b010;
    localparam logic [63:0] PAT  = 64'h9E37_79B9_7F4A_7C15;

    typedef struct packed {
        logic [3:0]  code;
        logic [6:0]  len;
        logic [63:0] cap;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{code: 4'h2, len: 7'd32, cap: {32'd0, IDX}},
        '{code: 4'h8, len: 7'd35, cap: {29'd0, RES, ACK}},
        '{code: 4'hF, len: 7'd1,  cap: 64'd0},
        '{code: 4'h0, len: 7'd1,  cap: 64'd0},
        '{code: 4'h5, len: 7'd1,  cap: 64'd0},
        '{code: 4'hA, len: 7'd1,  cap: 64'd0}
    };

    logic        tck = 1'b0;
    logic        por_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo, tdo_oe, dbg_req_valid;
    logic [3:0]  cur_instr;
    logic [34:0] dbg_req_data;

    int tests = 0;
    int fails = 0;
    logic last_oe;
    bit   done = 0;

    always #2.5 tck = ~tck;

    tap_port #(.ID_VALUE(IDV), .DATA_W(32), .ACK_W(3)) uut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi),
        .dbg_result(RES), .dbg_ack(ACK), .tdo(tdo), .tdo_oe(tdo_oe),
        .cur_instr(cur_instr), .dbg_req_data(dbg_req_data),
        .dbg_req_valid(dbg_req_valid));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read tdo after the falling edge, then drive inputs for the next rising edge.
    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck); #1;
        o = tdo; last_oe = tdo_oe;
        tms = m; tdi = d;
        @(posedge tck);
    endtask

    task automatic go_reset();
        logic o;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    // From Run-Test/Idle: load an instruction, return captured bits.
    task automatic ir_load(input logic [3:0] code, output logic [3:0] cap);
        logic o;
        step(1'b1, 1'b0, o); step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, code[i], o);
            cap[i] = o;
        end
        step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    endtask

    // From Run-Test/Idle: scan n bits through the selected data chain.
    task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        dout = '0;
        step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            dout[i] = o;
        end
        step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0]  icap;
        logic [63:0] dout, exp;
        logic        o;

        repeat (3) @(posedge tck);
        @(negedge tck); #1;
        // R3: reset state
        check("R3 oe", 64'(tdo_oe), 64'd0);
        check("R3 instr", 64'(cur_instr), 64'h2);
        por_n = 1'b1; tms = 1'b0;
        @(posedge tck);

        // R7: default instruction exposes the identification chain
        dr_scan(32, 64'd0, dout);
        check("R7 default id", dout, {32'd0, IDX});

        // R4: instruction capture pattern
        ir_load(4'hF, icap);
        check("R4 ir capture", 64'(icap), 64'h1);

        // R5 R6 R7 R8: vector table over instruction codes
        foreach (VECS[k]) begin
            ir_load(VECS[k].code, icap);
            dr_scan(64, PAT, dout);
            for (int i = 0; i < 64; i++)
                exp[i] = (i < int'(VECS[k].len)) ? VECS[k].cap[i] : PAT[i - int'(VECS[k].len)];
            check("R5 chain per code", dout, exp);
        end

        // R9: debug update strobe and data
        ir_load(4'h8, icap);
        dr_scan(35, 64'h5_1234_ABCD, dout);
        @(negedge tck); #1;
        check("R9 valid", 64'(dbg_req_valid), 64'd1);
        check("R9 data", 64'(dbg_req_data), 64'h5_1234_ABCD);
        step(1'b0, 1'b0, o);
        @(negedge tck); #1;
        check("R9 pulse width", 64'(dbg_req_valid), 64'd0);

        // R9: update with another instruction leaves debug word alone
        ir_load(4'hF, icap);
        dr_scan(8, 64'hFF, dout);
        @(negedge tck); #1;
        check("R9 no update", {28'd0, dbg_req_valid, dbg_req_data}, {29'd0, 35'h5_1234_ABCD});

        // R10: enable moves on the falling edge, only in Shift
        step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
        #1;
        check("R10 oe before fall", 64'(tdo_oe), 64'd0);
        step(1'b0, 1'b1, o);
        check("R10 oe after fall", 64'(last_oe), 64'd1);
        step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
        check("R10 oe in pause", 64'(last_oe), 64'd0);

        // R2 R1: five high mode bits from Pause-DR reach reset
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        #1;
        check("R2 instr in reset", 64'(cur_instr), 64'h2);
        step(1'b0, 1'b0, o);
        @(negedge tck); #1;
        check("R2 debug cleared", 64'(dbg_req_data), 64'd0);

        // R3: power-on reset mid-operation
        ir_load(4'h8, icap);
        @(negedge tck); por_n = 1'b0;
        repeat (2) @(posedge tck);
        @(negedge tck); #1;
        check("R3 instr after por", 64'(cur_instr), 64'h2);
        por_n = 1'b1; tms = 1'b0;
        @(posedge tck);
        dr_scan(32, 64'd0, dout);
        check("R3 id after por", dout, {32'd0, IDX});

        go_reset();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule